// File: doc/BRIEF.md
# Pull-Mode Link Word Distributor

This block is the shared transmit data path of a network interface whose outgoing links are physical wires rather than time slots. Every outgoing wire has its own parallel-to-serial converter. A single distributor and a single queue-side requester serve all of those converters, in place of one distributor per source queue. At connection setup, each converter is tied to one source queue through a small binding table. From then on a converter that has run dry pulls its next 32-bit word by raising a request.

A request identifies the converter by its index. The block arbitrates among pending requests in round-robin order and looks up the bound queue. It pops one word from that queue and returns the word with a valid strobe and a one-hot destination code that names the converter. Transactions are handled strictly one at a time. A grant takes one cycle and the pop-and-return takes a second, so the block returns at most one word every two cycles. If the bound queue is empty, the transaction waits in place and nothing is popped until that queue has data again.

Top module: `sdm_pull_distributor`

## Requirements
- R1: After reset, `ret_valid_o` and `q_pop_o` are low. Converter i is bound to queue i modulo NUM_Q (with defaults: converters 0..7 to queues 0,1,2,0,1,2,0,1).
- R2: A request from converter s, raised while the block is idle and the bound queue is non-empty, produces a pop of exactly that queue. The word comes back on `ret_valid_o` at the second rising edge after the request is first sampled, with `ret_sid_o` equal to 1 << s.
- R3: `ret_data_o` equals the head word that the bound queue presented on `q_data_i` in the cycle it was popped. Queue q occupies bits [q*32 +: 32].
- R4: With several requests pending together, grants go in ascending index order with wrap-around. The order starts at the index after the most recently served converter, and no converter is served twice while another waits.
- R5: While the bound queue reports empty, the granted transaction pops nothing and returns nothing. It completes in the first cycle the queue reports non-empty, and the word is visible after that cycle's edge.
- R6: A configuration write with `cfg_we_i` high binds converter `cfg_ser_i` to queue `cfg_queue_i`, provided that converter's request is low. Later requests from it pop the new queue.
- R7: A configuration write to a converter whose request is high is ignored, and its binding is unchanged.
- R8: At most one queue is popped per cycle, and never a queue that reports empty.
- R9: One transaction at a time: `ret_valid_o` is never high in two consecutive cycles, and no pop directly follows another pop.
- R10: A configuration write naming a queue index of NUM_Q or above is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_req_i | input | NUM_SER | Level request per converter. Held until its word is returned, then dropped |
| cfg_we_i | input | 1 | Binding write strobe |
| cfg_ser_i | input | clog2(NUM_SER) | Converter index to bind |
| cfg_queue_i | input | clog2(NUM_Q) | Queue index for the binding |
| q_empty_i | input | NUM_Q | Per-queue empty flag |
| q_data_i | input | NUM_Q*DATA_W | Head word of each queue, with queue q at bits [q*DATA_W +: DATA_W] |
| q_pop_o | output | NUM_Q | One-hot pop strobe |
| ret_valid_o | output | 1 | Returned word is valid this cycle |
| ret_sid_o | output | NUM_SER | One-hot destination converter |
| ret_data_o | output | DATA_W | Returned word |

## Verification
A corrupted binding entry shows up on the first request from the affected converter: two cycles later the wrong queue is popped and the wrong word is returned. A stuck round-robin pointer shows within one burst of simultaneous requests, because the sequence of one-hot destinations comes out of order. A state register that fails to return to idle shows as a missing strobe, and one that leaves service early shows as a pop against an empty queue. Both appear within the two-cycle transaction window.

// File: rtl/sdm_dist_pkg.sv
package sdm_dist_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SERVE = 1'b1
  } dist_state_e;
endpackage

// File: rtl/sdm_rr_arbiter.sv
module sdm_rr_arbiter #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req_i,
  input  logic             adv_i,
  output logic             gnt_valid_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  logic [IDX_W-1:0] ptr_q, ptr_d;
  int unsigned      cand;

  // Search starts one past the last winner; the nearest requester wins.
  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    cand        = 0;
    for (int k = N - 1; k >= 0; k--) begin
      cand = (32'(ptr_q) + 32'd1 + 32'(k)) % N;
      if (req_i[cand[IDX_W-1:0]]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = cand[IDX_W-1:0];
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv_i && gnt_valid_o) ptr_d = gnt_idx_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= IDX_W'(N - 1);
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/sdm_bind_table.sv
module sdm_bind_table #(
  parameter int NUM_SER = 8,
  parameter int NUM_Q   = 3,
  localparam int SER_W  = (NUM_SER > 1) ? $clog2(NUM_SER) : 1,
  localparam int QID_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [SER_W-1:0]   wr_ser_i,
  input  logic [QID_W-1:0]   wr_q_i,
  input  logic [NUM_SER-1:0] ser_busy_i,
  input  logic [SER_W-1:0]   rd_ser_i,
  output logic [QID_W-1:0]   rd_q_o
);
  logic [QID_W-1:0] tbl_q [NUM_SER];
  logic             q_in_range;

  assign q_in_range = ({1'b0, wr_q_i} < (QID_W + 1)'(NUM_Q));

  for (genvar i = 0; i < NUM_SER; i++) begin : g_entry
    logic             wr_hit;
    logic [QID_W-1:0] entry_d;

    always_comb begin
      wr_hit  = wr_en_i && (wr_ser_i == SER_W'(i)) && !ser_busy_i[i] && q_in_range;
      entry_d = wr_hit ? wr_q_i : tbl_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tbl_q[i] <= QID_W'(i % NUM_Q);
      else        tbl_q[i] <= entry_d;
    end
  end

  assign rd_q_o = tbl_q[rd_ser_i];
endmodule

// File: rtl/sdm_return_path.sv
module sdm_return_path #(
  parameter int NUM_SER = 8,
  parameter int NUM_Q   = 3,
  parameter int DATA_W  = 32,
  localparam int SER_W  = (NUM_SER > 1) ? $clog2(NUM_SER) : 1,
  localparam int QID_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    serve_i,
  input  logic [QID_W-1:0]        q_sel_i,
  input  logic [SER_W-1:0]        ser_sel_i,
  input  logic [NUM_Q-1:0]        q_empty_i,
  input  logic [NUM_Q*DATA_W-1:0] q_data_i,
  output logic [NUM_Q-1:0]        q_pop_o,
  output logic                    done_o,
  output logic                    ret_valid_o,
  output logic [NUM_SER-1:0]      ret_sid_o,
  output logic [DATA_W-1:0]       ret_data_o
);
  logic              head_empty;
  logic [DATA_W-1:0] head_word;
  logic              valid_d;
  logic [NUM_SER-1:0] sid_d;

  always_comb begin
    head_empty = 1'b1;
    head_word  = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      if (q_sel_i == QID_W'(q)) begin
        head_empty = q_empty_i[q];
        head_word  = q_data_i[q*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    done_o  = serve_i && !head_empty;
    q_pop_o = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      if (done_o && (q_sel_i == QID_W'(q))) q_pop_o[q] = 1'b1;
    end
    valid_d = done_o;
    sid_d   = NUM_SER'(1) << ser_sel_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ret_valid_o <= 1'b0;
    else        ret_valid_o <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_sid_o  <= '0;
      ret_data_o <= '0;
    end else if (done_o) begin
      ret_sid_o  <= sid_d;
      ret_data_o <= head_word;
    end
  end
endmodule

// File: rtl/sdm_pull_distributor.sv
module sdm_pull_distributor
  import sdm_dist_pkg::*;
#(
  parameter int NUM_SER = 8,
  parameter int NUM_Q   = 3,
  parameter int DATA_W  = 32,
  localparam int SER_W  = (NUM_SER > 1) ? $clog2(NUM_SER) : 1,
  localparam int QID_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SER-1:0]      ser_req_i,
  input  logic                    cfg_we_i,
  input  logic [SER_W-1:0]        cfg_ser_i,
  input  logic [QID_W-1:0]        cfg_queue_i,
  input  logic [NUM_Q-1:0]        q_empty_i,
  input  logic [NUM_Q*DATA_W-1:0] q_data_i,
  output logic [NUM_Q-1:0]        q_pop_o,
  output logic                    ret_valid_o,
  output logic [NUM_SER-1:0]      ret_sid_o,
  output logic [DATA_W-1:0]       ret_data_o
);
  dist_state_e       state_q, state_d;
  logic [SER_W-1:0]  cur_ser_q, cur_ser_d;
  logic [QID_W-1:0]  cur_q_q, cur_q_d;
  logic [NUM_SER-1:0] arb_req;
  logic              gnt_valid, arb_adv, serve, done;
  logic [SER_W-1:0]  gnt_idx;
  logic [QID_W-1:0]  bound_q;

  // The converter whose word is being handed over this cycle still holds
  // its request; keep it out of arbitration.
  assign arb_req = ser_req_i & ~(ret_valid_o ? ret_sid_o : '0);
  assign arb_adv = (state_q == ST_IDLE);
  assign serve   = (state_q == ST_SERVE);

  sdm_rr_arbiter #(.N(NUM_SER)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (arb_req),
    .adv_i      (arb_adv),
    .gnt_valid_o(gnt_valid),
    .gnt_idx_o  (gnt_idx)
  );

  sdm_bind_table #(.NUM_SER(NUM_SER), .NUM_Q(NUM_Q)) u_bind (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (cfg_we_i),
    .wr_ser_i  (cfg_ser_i),
    .wr_q_i    (cfg_queue_i),
    .ser_busy_i(ser_req_i),
    .rd_ser_i  (gnt_idx),
    .rd_q_o    (bound_q)
  );

  sdm_return_path #(.NUM_SER(NUM_SER), .NUM_Q(NUM_Q), .DATA_W(DATA_W)) u_ret (
    .clk        (clk),
    .rst_n      (rst_n),
    .serve_i    (serve),
    .q_sel_i    (cur_q_q),
    .ser_sel_i  (cur_ser_q),
    .q_empty_i  (q_empty_i),
    .q_data_i   (q_data_i),
    .q_pop_o    (q_pop_o),
    .done_o     (done),
    .ret_valid_o(ret_valid_o),
    .ret_sid_o  (ret_sid_o),
    .ret_data_o (ret_data_o)
  );

  always_comb begin
    state_d   = state_q;
    cur_ser_d = cur_ser_q;
    cur_q_d   = cur_q_q;
    unique case (state_q)
      ST_IDLE: begin
        if (gnt_valid) begin
          state_d   = ST_SERVE;
          cur_ser_d = gnt_idx;
          cur_q_d   = bound_q;
        end
      end
      ST_SERVE: begin
        if (done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cur_ser_q <= '0;
      cur_q_q   <= '0;
    end else begin
      state_q   <= state_d;
      cur_ser_q <= cur_ser_d;
      cur_q_q   <= cur_q_d;
    end
  end
endmodule

// File: rtl/sdm_dist_checker.sv
module sdm_dist_checker #(
  parameter int NUM_SER = 8,
  parameter int NUM_Q   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SER-1:0] ser_req_i,
  input logic [NUM_Q-1:0]   q_empty_i,
  input logic [NUM_Q-1:0]   q_pop_o,
  input logic               ret_valid_o,
  input logic [NUM_SER-1:0] ret_sid_o
);
  AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(q_pop_o)); // R8
  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (q_pop_o & q_empty_i) == '0); // R8
  AST_RET_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n) ret_valid_o |-> $past(|q_pop_o)); // R2
  AST_RET_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) ret_valid_o |-> ($countones(ret_sid_o) == 1)); // R2
  AST_RET_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n) ret_valid_o |-> ((ret_sid_o & $past(ser_req_i)) != '0)); // R2
  AST_ONE_RETURN: assert property (@(posedge clk) disable iff (!rst_n) ret_valid_o |=> !ret_valid_o); // R9
  AST_POP_SPACING: assert property (@(posedge clk) disable iff (!rst_n) (|q_pop_o) |=> !(|q_pop_o)); // R9
endmodule

bind sdm_pull_distributor sdm_dist_checker #(.NUM_SER(NUM_SER), .NUM_Q(NUM_Q)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ser_req_i  (ser_req_i),
  .q_empty_i  (q_empty_i),
  .q_pop_o    (q_pop_o),
  .ret_valid_o(ret_valid_o),
  .ret_sid_o  (ret_sid_o)
);

// File: tb/sdm_pull_distributor_bench.sv
module sdm_pull_distributor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int NQ = 3;
  localparam int DW = 32;

  logic            clk;
  logic            rst_n;
  logic [NS-1:0]   ser_req;
  logic            cfg_we;
  logic [2:0]      cfg_ser;
  logic [1:0]      cfg_queue;
  logic [NQ-1:0]   q_hold;
  logic [NQ-1:0]   q_empty;
  logic [NQ*DW-1:0] q_data;
  logic [NQ-1:0]   q_pop;
  logic            ret_valid;
  logic [NS-1:0]   ret_sid;
  logic [DW-1:0]   ret_data;

  int pop_cnt [NQ];
  int bad_pop;
  int bound [NS];
  int last_ser;
  int checks;
  int errors;
  bit finished;

  // Table rows: {converter[2:0], queue[1:0]}
  localparam logic [4:0] VEC [8] = '{
    {3'd0, 2'd2}, {3'd3, 2'd1}, {3'd7, 2'd0}, {3'd5, 2'd2},
    {3'd1, 2'd0}, {3'd6, 2'd1}, {3'd2, 2'd2}, {3'd4, 2'd0}
  };

  sdm_pull_distributor u_sdm_pull_distributor (
    .clk(clk), .rst_n(rst_n), .ser_req_i(ser_req), .cfg_we_i(cfg_we),
    .cfg_ser_i(cfg_ser), .cfg_queue_i(cfg_queue), .q_empty_i(q_empty),
    .q_data_i(q_data), .q_pop_o(q_pop), .ret_valid_o(ret_valid),
    .ret_sid_o(ret_sid), .ret_data_o(ret_data)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  function automatic logic [31:0] word_of(int q, int c);
    word_of = {8'hC0 + 8'(q), 8'h5A, 16'(c)};
  endfunction

  assign q_empty = q_hold;
  always_comb
    for (int q = 0; q < NQ; q++) q_data[q*DW +: DW] = word_of(q, pop_cnt[q]);

  // Queue model: heads advance on pop
  always @(posedge clk) begin
    if (rst_n) begin
      if ($countones(q_pop) > 1) bad_pop = bad_pop + 1;
      for (int q = 0; q < NQ; q++) begin
        if (q_pop[q]) begin
          if (q_empty[q]) bad_pop = bad_pop + 1;
          pop_cnt[q] = pop_cnt[q] + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_bind(input int s, input int q);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ser = 3'(s); cfg_queue = 2'(q);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_request(input int s, input int q, input string tag);
    int c0;
    c0 = pop_cnt[q];
    ser_req[s] = 1'b1;
    @(negedge clk);
    check(ret_valid == 1'b0, {tag, " R2 latency"}, 32'(ret_valid), 32'd0);
    @(negedge clk);
    check(ret_valid == 1'b1, {tag, " R2 valid"}, 32'(ret_valid), 32'd1);
    check(ret_sid == NS'(1 << s), {tag, " R2 sid"}, 32'(ret_sid), 32'(1 << s));
    check(ret_data == word_of(q, c0), {tag, " R3 data"}, ret_data, word_of(q, c0));
    check(pop_cnt[q] == c0 + 1, {tag, " R2 pop"}, 32'(pop_cnt[q]), 32'(c0 + 1));
    ser_req[s] = 1'b0;
    last_ser = s;
    @(negedge clk);
    check(ret_valid == 1'b0, {tag, " R9 single"}, 32'(ret_valid), 32'd0);
  endtask

  initial begin
    finished = 1'b0;
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0;
    int order_ok;
    int exp_s;
    logic [NS-1:0] pend;
    checks = 0; errors = 0; bad_pop = 0; last_ser = NS - 1;
    for (int q = 0; q < NQ; q++) pop_cnt[q] = 0;
    for (int i = 0; i < NS; i++) bound[i] = i % NQ;
    rst_n = 1'b0; ser_req = '0; cfg_we = 1'b0; cfg_ser = '0; cfg_queue = '0; q_hold = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ret_valid == 1'b0, "R1 ret_valid reset", 32'(ret_valid), 32'd0);
    check(q_pop == '0, "R1 pop reset", 32'(q_pop), 32'd0);
    // R1 default binding: converter 4 -> queue 1, converter 6 -> queue 0
    do_request(4, 1, "R1 default s4");
    do_request(6, 0, "R1 default s6");

    // R6 table-driven rebinding
    for (int i = 0; i < 8; i++) begin
      do_bind(int'(VEC[i][4:2]), int'(VEC[i][1:0]));
      bound[VEC[i][4:2]] = int'(VEC[i][1:0]);
      do_request(int'(VEC[i][4:2]), int'(VEC[i][1:0]), "R6 vector");
    end

    // R5 empty queue stall: converter 0 bound to queue 2
    q_hold[2] = 1'b1;
    c0 = pop_cnt[2];
    ser_req[0] = 1'b1;
    // R7 write while requesting must be ignored
    cfg_we = 1'b1; cfg_ser = 3'd0; cfg_queue = 2'd1;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check(ret_valid == 1'b0, "R5 no return while empty", 32'(ret_valid), 32'd0);
    end
    check(pop_cnt[2] == c0, "R5 no pop while empty", 32'(pop_cnt[2]), 32'(c0));
    q_hold[2] = 1'b0;
    @(negedge clk);
    check(ret_valid == 1'b1, "R5 return after refill", 32'(ret_valid), 32'd1);
    check(ret_data == word_of(2, c0), "R5 data", ret_data, word_of(2, c0));
    ser_req[0] = 1'b0;
    last_ser = 0;
    @(negedge clk);
    do_request(0, 2, "R7 binding kept");

    // R10 out-of-range queue index ignored
    do_bind(5, 3);
    do_request(5, bound[5], "R10 binding kept");

    // R4 round robin over simultaneous requests
    pend = 8'b1011_0101;
    ser_req = pend;
    exp_s = last_ser;
    for (int n = 0; n < 5; n++) begin
      exp_s = (exp_s + 1) % NS;
      while (!pend[exp_s]) exp_s = (exp_s + 1) % NS;
      order_ok = 0;
      for (int w = 0; w < 8 && order_ok == 0; w++) begin
        @(negedge clk);
        if (ret_valid) order_ok = 1;
      end
      check(ret_valid && ret_sid == NS'(1 << exp_s), "R4 grant order", 32'(ret_sid), 32'(1 << exp_s));
      ser_req = ser_req & ~ret_sid;
      pend = pend & ~ret_sid;
    end
    @(negedge clk);
    check(bad_pop == 0, "R8 pop legality", 32'(bad_pop), 32'd0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule